// File: doc/BRIEF.md
# Wide Bit-Field Extract and Insert Unit

This unit works on a wide operand made of two N-bit words, a high word and a low word, which together form one 2N-bit value. It has two jobs. Extraction pulls a field of `size` bits, starting at bit `pos`, out of the pair and returns it as one N-bit word. The upper bits of that word are either cleared or filled with the field's top bit. Insertion writes the low `size` bits of a narrow operand into the same kind of field and returns the whole pair with every other bit left as it was. A field may cross the boundary between the low and high words, which is the usual case when a decoder steps through a bitstream held in a register pair.

A command is presented with `in_valid`. The unit registers the result, and it appears one clock later with `out_valid`. A small two-state controller tracks whether the output registers hold a result issued in the previous cycle. Its states are `ST_IDLE` and `ST_RESULT`. The transitions are named launch (ST_IDLE to ST_RESULT on `in_valid`), chain (ST_RESULT stays in ST_RESULT on `in_valid`), retire (ST_RESULT to ST_IDLE when `in_valid` is low) and rest (ST_IDLE stays in ST_IDLE when `in_valid` is low). A field that does not fit the pair is flagged as an error and gives a defined result.

Top module: `bfx_unit`

## Requirements
- R1: With `in_op` = 2'b00 (zero-extending extract), `out_narrow` bit k equals bit `pos`+k of {`in_hi`,`in_lo`} for k < `size`, and every higher bit is 0. Bit 0 of `in_lo` is bit 0 of the pair, and bit 0 of `in_hi` is bit N.
- R2: With `in_op` = 2'b01 (sign-extending extract), the field bits are placed as in R1, and every bit of `out_narrow` at or above `size` equals field bit `size`-1.
- R3: Extraction and insertion give correct results for fields that hold bits from both `in_lo` and `in_hi`.
- R4: With `in_op[1]` = 1 (insert), {`out_hi`,`out_lo`} equals {`in_hi`,`in_lo`}, except that bits `pos` to `pos`+`size`-1 take bits 0 to `size`-1 of `in_narrow`.
- R5: An insert ignores the bits of `in_narrow` at or above `size`.
- R6: The unit treats a command as illegal when `size` is 0, when `size` is greater than N, or when `pos`+`size` is greater than 2N. For an illegal command it sets `out_err` to 1. An illegal extract returns `out_narrow` = 0. An illegal insert returns {`out_hi`,`out_lo`} equal to the input pair. For a legal command `out_err` is 0.
- R7: `out_valid` is 1 in exactly the cycle after each cycle in which `in_valid` is 1. When `in_valid` is 0, all result outputs keep their values.
- R8: An extract drives `out_hi` and `out_lo` to 0. An insert drives `out_narrow` to 0.
- R9: While `rst_n` is low and after it is released, `out_valid`, `out_err` and all result outputs are 0 until the first command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command strobe |
| in_op | input | 2 | 00 extract zero-extend, 01 extract sign-extend, 1x insert |
| in_size | input | $clog2(N)+1 | Field width in bits |
| in_pos | input | $clog2(2N) | Field start bit, counted from bit 0 of the low word |
| in_hi | input | N | High word of the wide operand |
| in_lo | input | N | Low word of the wide operand |
| in_narrow | input | N | Value to insert |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_err | output | 1 | Illegal field flag |
| out_narrow | output | N | Extract result |
| out_hi | output | N | High word of the insert result |
| out_lo | output | N | Low word of the insert result |

## Verification
Every result, including the error flag and the cleared outputs, is due exactly one clock after the cycle in which its command was presented, and it must hold until the next command. The bench applies commands on the falling edge. On each following falling edge it compares all outputs with a behavioural model, whose expected values were computed when the command was applied. One edge therefore separates a command from its check. Idle gaps, back-to-back commands and illegal fields are all checked against that same one-cycle rule.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

    typedef enum logic [1:0] {
        BFX_EXTU    = 2'b00,
        BFX_EXTS    = 2'b01,
        BFX_INS     = 2'b10,
        BFX_INS_ALT = 2'b11
    } bfx_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } bfx_state_e;

endpackage

// File: rtl/bfx_mask_gen.sv
module bfx_mask_gen #(
    parameter int N  = 32,
    parameter int SW = $clog2(N) + 1
) (
    input  logic [SW-1:0] size,
    output logic [N-1:0]  low_mask
);
    // one comparator per bit: bit g is set when g lies inside the field width
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign low_mask[g] = (SW'(g) < size);
    end
endmodule

// File: rtl/bfx_range_chk.sv
module bfx_range_chk #(
    parameter int N  = 32,
    parameter int SW = $clog2(N) + 1,
    parameter int PW = $clog2(2 * N)
) (
    input  logic [SW-1:0] size,
    input  logic [PW-1:0] pos,
    output logic          illegal
);
    localparam int EW = ((PW > SW) ? PW : SW) + 2;

    logic [EW-1:0] span;

    assign span    = EW'(pos) + EW'(size);
    assign illegal = (size == '0) || (EW'(size) > EW'(N)) || (span > EW'(2 * N));
endmodule

// File: rtl/bfx_extract.sv
module bfx_extract #(
    parameter int N  = 32,
    parameter int PW = $clog2(2 * N)
) (
    input  logic [2*N-1:0] wide,
    input  logic [PW-1:0]  pos,
    input  logic [N-1:0]   low_mask,
    input  logic           sign_sel,
    output logic [N-1:0]   field
);
    logic [2*N-1:0] shifted;
    logic [N-1:0]   raw;
    logic [N-1:0]   top_mask;
    logic           fill;

    assign shifted  = wide >> pos;
    assign raw      = shifted[N-1:0] & low_mask;
    // the single set bit marks the field's most significant position
    assign top_mask = low_mask & ~(low_mask >> 1);
    assign fill     = sign_sel & (|(raw & top_mask));
    assign field    = raw | ({N{fill}} & ~low_mask);
endmodule

// File: rtl/bfx_insert.sv
module bfx_insert #(
    parameter int N  = 32,
    parameter int PW = $clog2(2 * N)
) (
    input  logic [2*N-1:0] wide,
    input  logic [N-1:0]   narrow,
    input  logic [PW-1:0]  pos,
    input  logic [N-1:0]   low_mask,
    output logic [2*N-1:0] merged
);
    logic [2*N-1:0] place_mask;
    logic [2*N-1:0] placed;

    assign place_mask = {{N{1'b0}}, low_mask} << pos;
    assign placed     = {{N{1'b0}}, narrow & low_mask} << pos;
    assign merged     = (wide & ~place_mask) | placed;
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
    import bfx_pkg::*;
#(
    parameter int N  = 32,
    parameter int SW = $clog2(N) + 1,
    parameter int PW = $clog2(2 * N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    in_op,
    input  logic [SW-1:0] in_size,
    input  logic [PW-1:0] in_pos,
    input  logic [N-1:0]  in_hi,
    input  logic [N-1:0]  in_lo,
    input  logic [N-1:0]  in_narrow,
    output logic          out_valid,
    output logic          out_err,
    output logic [N-1:0]  out_narrow,
    output logic [N-1:0]  out_hi,
    output logic [N-1:0]  out_lo
);
    bfx_op_e     op;
    bfx_state_e  state, state_nx;
    logic [N-1:0]   low_mask;
    logic           illegal;
    logic [N-1:0]   ext_field;
    logic [2*N-1:0] ins_pair;
    logic [2*N-1:0] in_pair;
    logic           is_insert;

    assign op        = bfx_op_e'(in_op);
    assign in_pair   = {in_hi, in_lo};
    assign is_insert = (op == BFX_INS) || (op == BFX_INS_ALT);

    bfx_mask_gen #(.N(N), .SW(SW)) u_mask (
        .size     (in_size),
        .low_mask (low_mask)
    );

    bfx_range_chk #(.N(N), .SW(SW), .PW(PW)) u_range (
        .size    (in_size),
        .pos     (in_pos),
        .illegal (illegal)
    );

    bfx_extract #(.N(N), .PW(PW)) u_ext (
        .wide     (in_pair),
        .pos      (in_pos),
        .low_mask (low_mask),
        .sign_sel (op == BFX_EXTS),
        .field    (ext_field)
    );

    bfx_insert #(.N(N), .PW(PW)) u_ins (
        .wide     (in_pair),
        .narrow   (in_narrow),
        .pos      (in_pos),
        .low_mask (low_mask),
        .merged   (ins_pair)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: launch, chain, retire, rest
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_nx = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    assign out_valid = (state == ST_RESULT);

    // output registers, loaded only when a command is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_err    <= 1'b0;
            out_narrow <= '0;
            out_hi     <= '0;
            out_lo     <= '0;
        end else if (in_valid) begin
            out_err <= illegal;
            if (is_insert) begin
                out_narrow        <= '0;
                {out_hi, out_lo}  <= illegal ? in_pair : ins_pair;
            end else begin
                out_narrow <= illegal ? '0 : ext_field;
                out_hi     <= '0;
                out_lo     <= '0;
            end
        end
    end
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk #(
    parameter int N  = 32,
    parameter int SW = $clog2(N) + 1,
    parameter int PW = $clog2(2 * N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [1:0]    in_op,
    input logic [SW-1:0] in_size,
    input logic [PW-1:0] in_pos,
    input logic [N-1:0]  in_hi,
    input logic [N-1:0]  in_lo,
    input logic [N-1:0]  in_narrow,
    input logic          out_valid,
    input logic          out_err,
    input logic [N-1:0]  out_narrow,
    input logic [N-1:0]  out_hi,
    input logic [N-1:0]  out_lo
);
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R7

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_narrow) && $stable(out_hi) && $stable(out_lo) && $stable(out_err)));  // R7

    AST_ZERO_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == '0) |=> out_err);  // R6

    AST_ERR_INS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[1] && in_size == '0) |=> ({out_hi, out_lo} == $past({in_hi, in_lo})));  // R6

    AST_ERR_EXT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_op[1] && in_size == '0) |=> (out_narrow == '0));  // R6

    AST_EXT_WIDE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_op[1]) |=> (out_hi == '0 && out_lo == '0));  // R8

    AST_INS_NARROW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[1]) |=> (out_narrow == '0));  // R8

    AST_FULL_EXTU_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b00 && in_size == SW'(N) && in_pos == '0) |=> (out_narrow == $past(in_lo)));  // R1
endmodule

bind bfx_unit bfx_unit_chk #(.N(N), .SW(SW), .PW(PW)) u_bfx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_size    (in_size),
    .in_pos     (in_pos),
    .in_hi      (in_hi),
    .in_lo      (in_lo),
    .in_narrow  (in_narrow),
    .out_valid  (out_valid),
    .out_err    (out_err),
    .out_narrow (out_narrow),
    .out_hi     (out_hi),
    .out_lo     (out_lo)
);

// File: tb/test_bfx_unit.sv
module test_bfx_unit;
    localparam int N      = 32;
    localparam int SW     = $clog2(N) + 1;
    localparam int PW     = $clog2(2 * N);
    localparam int CLK_NS = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [1:0]    in_op;
    logic [SW-1:0] in_size;
    logic [PW-1:0] in_pos;
    logic [N-1:0]  in_hi, in_lo, in_narrow;
    logic          out_valid, out_err;
    logic [N-1:0]  out_narrow, out_hi, out_lo;

    int checks = 0;
    int fails  = 0;

    // model state
    logic          m_valid = 1'b0;
    logic          m_err   = 1'b0;
    logic [N-1:0]  m_nar   = '0;
    logic [2*N-1:0] m_wide = '0;
    string         m_tag   = "R9";

    always #(CLK_NS / 2) clk = ~clk;

    bfx_unit #(.N(N)) i_bfx_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_size(in_size), .in_pos(in_pos), .in_hi(in_hi), .in_lo(in_lo),
        .in_narrow(in_narrow), .out_valid(out_valid), .out_err(out_err),
        .out_narrow(out_narrow), .out_hi(out_hi), .out_lo(out_lo)
    );

    task automatic compare();
        checks++;
        if (out_valid !== m_valid || out_err !== m_err || out_narrow !== m_nar ||
            {out_hi, out_lo} !== m_wide) begin
            fails++;
            $display("FAIL %s: got v=%0b e=%0b n=%h w=%h%h, expected v=%0b e=%0b n=%h w=%h",
                     m_tag, out_valid, out_err, out_narrow, out_hi, out_lo,
                     m_valid, m_err, m_nar, m_wide);
        end
    endtask

    // one cycle: check the result due now, then present the next command
    task automatic step(input logic v, input logic [1:0] op, input int size, input int pos,
                        input logic [N-1:0] hi, input logic [N-1:0] lo,
                        input logic [N-1:0] nar, input string tag);
        logic [2*N-1:0] pair;
        logic [N-1:0]   r;
        logic           bad;
        @(negedge clk);
        compare();
        in_valid  = v;
        in_op     = op;
        in_size   = SW'(size);
        in_pos    = PW'(pos);
        in_hi     = hi;
        in_lo     = lo;
        in_narrow = nar;
        m_valid   = v;
        m_tag     = tag;
        if (v) begin
            pair = {hi, lo};
            bad  = (size == 0) || (size > N) || (pos + size > 2 * N);
            m_err = bad;
            if (op[1]) begin
                m_nar = '0;
                if (!bad)
                    for (int k = 0; k < size; k++) pair[pos + k] = nar[k];
                m_wide = pair;
            end else begin
                m_wide = '0;
                r = '0;
                if (!bad) begin
                    for (int k = 0; k < size; k++) r[k] = pair[pos + k];
                    if (op[0] && r[size - 1])
                        for (int k = size; k < N; k++) r[k] = 1'b1;
                end
                m_nar = r;
            end
        end
    endtask

    initial begin
        #(CLK_NS * 100000);
        fails++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_size = '0; in_pos = '0;
        in_hi = '0; in_lo = '0; in_narrow = '0;
        repeat (3) @(negedge clk);
        compare();  // R9 during reset
        rst_n = 1'b1;
        step(0, 2'b00, 0, 0, '0, '0, '0, "R9");
        step(0, 2'b00, 0, 0, '0, '0, '0, "R9");
        // R1 inside low word and at word edges
        step(1, 2'b00, 8, 4, 32'h1234_5678, 32'h9ABC_DEF0, '0, "R1");
        step(1, 2'b00, 32, 0, 32'h1234_5678, 32'h9ABC_DEF0, '0, "R1");
        step(1, 2'b00, 32, 32, 32'h1234_5678, 32'h9ABC_DEF0, '0, "R1");
        step(1, 2'b00, 4, 60, 32'hF234_5678, 32'h0, '0, "R1");
        // R2 negative and positive fields
        step(1, 2'b01, 8, 0, 32'h0, 32'h0000_0080, '0, "R2");
        step(1, 2'b01, 8, 0, 32'h0, 32'h0000_007F, '0, "R2");
        step(1, 2'b01, 1, 63, 32'h8000_0000, 32'h0, '0, "R2");
        // R3 straddling fields
        step(1, 2'b00, 8, 28, 32'h0000_000A, 32'hB000_0000, '0, "R3");
        step(1, 2'b01, 16, 24, 32'h0000_00F1, 32'h2300_0000, '0, "R3");
        step(1, 2'b10, 12, 26, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, "R3");
        // R4 insert, R5 high garbage ignored
        step(1, 2'b10, 8, 8, 32'hAAAA_AAAA, 32'h5555_5555, 32'h0000_00C3, "R4");
        step(1, 2'b11, 32, 16, 32'h0, 32'h0, 32'hDEAD_BEEF, "R4");
        step(1, 2'b10, 4, 0, 32'h0, 32'h0, 32'hFFFF_FFF9, "R5");
        // R6 illegal fields
        step(1, 2'b00, 0, 5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, '0, "R6");
        step(1, 2'b01, 33, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, '0, "R6");
        step(1, 2'b00, 4, 61, 32'hFFFF_FFFF, 32'hFFFF_FFFF, '0, "R6");
        step(1, 2'b10, 8, 60, 32'h1357_9BDF, 32'h2468_ACE0, 32'hFF, "R6");
        // R7 hold over idle gap, then R8 op switch
        step(0, 2'b10, 5, 5, 32'h1, 32'h1, 32'h1, "R7");
        step(0, 2'b00, 5, 5, 32'h1, 32'h1, 32'h1, "R7");
        step(1, 2'b01, 16, 8, 32'hFFFF_FFFF, 32'h00FF_FF00, '0, "R8");
        step(1, 2'b10, 16, 8, 32'hFFFF_FFFF, 32'h00FF_FF00, 32'h1234, "R8");
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            step(1'($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)),
                 $urandom_range(0, 40), $urandom_range(0, 63),
                 $urandom, $urandom, $urandom, "R7");
        end
        step(0, 2'b00, 0, 0, '0, '0, '0, "R7");
        @(negedge clk);
        compare();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule